// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the slave side of a 256-byte serial memory reached over a two-wire bus. It runs on a system clock and oversamples the bus clock and data lines. It finds Start and Stop conditions and collects the device address byte. It answers with an acknowledge or a no-acknowledge by pulling an open-drain data line low. An 8-bit word pointer serves three kinds of read: reads at the current address, reads at an address the master chooses, and long sequential reads that wrap across the whole array.

Each received write byte leaves on a one-cycle strobe together with its address, so that a page buffer can collect it. The same strobe also updates an internal register file that holds the array contents. While the surrounding logic reports an internal write as busy, the engine refuses its device address. A master can therefore poll until the write has finished.

Top module: `twi_mem_slave`

## Requirements
- R1: After reset the data line is released and no write strobe is issued. A Start (data falling while the bus clock is high) begins a fresh device-address byte from any state, and a Stop (data rising while the bus clock is high) returns the engine to idle.
- R2: The device byte arrives MSB first. It is acknowledged only when bits 7..4 equal 1010 and bits 3..1 equal the three strap inputs (bit 3 against strap bit 2). Bit 0 selects read (1) or write (0).
- R3: After an unmatched device byte the engine returns a no-acknowledge and then ignores the bus until the next Start: it gives no acknowledge and no write strobe, and it keeps the data line released while idle.
- R4: In a write, the first byte after the device byte loads the word pointer. Each following byte is acknowledged and produces exactly one single-cycle strobe that carries the pointer value and the byte.
- R5: After each written byte only the low four pointer bits advance, so a write that crosses a 16-byte page boundary continues at the start of the same page.
- R6: A write of a word address, then a repeated Start and a read device byte, returns the byte stored at that address.
- R7: A read with no address phase returns the byte after the last one accessed. After a byte at address 255 it returns the byte at address 0.
- R8: In a read, every master acknowledge after a byte is followed by the next byte, with the pointer wrapping from 255 to 0. A master no-acknowledge ends the transfer.
- R9: While the busy input is high the device byte gets a no-acknowledge. Once busy is low again the same byte is acknowledged.
- R10: A Start in the middle of a byte discards the partial bits, and the transfer that follows behaves normally.
- R11: The data-line drive changes only on the system clock after a detected bus-clock falling edge, or after a Start or Stop, and it holds steady while the bus clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired-AND value) |
| strap_i | input | 3 | Device select straps compared with device byte bits 3..1 |
| busy_i | input | 1 | Internal write in progress; device byte is refused |
| sda_oe_o | output | 1 | 1 pulls the data line low (acknowledge or a 0 data bit) |
| wr_stb_o | output | 1 | One-cycle strobe for each received write byte |
| wr_addr_o | output | 8 | Word address of the strobed byte |
| wr_data_o | output | 8 | Value of the strobed byte |

## Verification
The bench targets the pointer boundaries. A write that crosses from offset 15 is checked to land back at the page start; a design that carried into the upper pointer bits would put the byte in the next page. Reads that cross address 255, both sequential and at the current address, must return address 0; a design with the wrong width or carry would return stale or undefined bytes. Every device address is swept against a fixed strap value, and the bench also covers refusal during busy, silence after a mismatch, and a Start in the middle of a byte. Each of these exposes an engine that acknowledges the wrong device, strobes while it should ignore the bus, or keeps partial bits across an abort. Read bits are sampled twice within each high phase of the bus clock, which catches a data line that moves while the clock is high.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam int BYTE_W   = 8;
  localparam int PREFIX_W = 4;
  localparam int STRAP_W  = 3;
  localparam logic [PREFIX_W-1:0] DEV_PREFIX = 4'b1010;

  typedef enum logic [3:0] {
    S_IDLE,
    S_DEV,
    S_ADEV,
    S_ADR,
    S_AADR,
    S_DAT,
    S_ADAT,
    S_TX,
    S_MACK
  } state_t;
endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic scl_q, sda_q, scl_s;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_i;
          sda_pipe <= sda_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
          sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  assign scl_s = scl_pipe[STAGES-1];
  assign sda_s = sda_pipe[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/twi_regfile.sv
module twi_regfile #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/twi_engine.sv
module twi_engine
  import twi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sda_s,
  input  logic                scl_rise,
  input  logic                scl_fall,
  input  logic                start_det,
  input  logic                stop_det,
  input  logic [STRAP_W-1:0]  strap,
  input  logic                busy,
  input  logic [BYTE_W-1:0]   rd_data,
  output logic [ADDR_W-1:0]   ptr,
  output logic                sda_oe,
  output logic                wr_stb,
  output logic [ADDR_W-1:0]   wr_addr,
  output logic [BYTE_W-1:0]   wr_data
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  state_t             state;
  logic [CNT_W-1:0]   cnt;
  logic [BYTE_W-1:0]  sh;
  logic               rw;
  logic               mack;
  logic               dev_ok;
  logic [ADDR_W-1:0]  page_next;

  assign dev_ok = (sh[BYTE_W-1 -: PREFIX_W] == DEV_PREFIX) &&
                  (sh[STRAP_W:1] == strap) && !busy;
  assign page_next = {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      cnt     <= '0;
      sh      <= '0;
      rw      <= 1'b0;
      mack    <= 1'b0;
      ptr     <= '0;
      sda_oe  <= 1'b0;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (start_det) begin
        state  <= S_DEV;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= S_IDLE;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          S_DEV, S_ADR, S_DAT: begin
            if (scl_rise && cnt != FULL) begin
              sh  <= {sh[BYTE_W-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == FULL) begin
              cnt <= '0;
              if (state == S_DEV) begin
                if (dev_ok) begin
                  sda_oe <= 1'b1;
                  rw     <= sh[0];
                  state  <= S_ADEV;
                end else begin
                  state  <= S_IDLE;
                end
              end else if (state == S_ADR) begin
                ptr    <= sh;
                sda_oe <= 1'b1;
                state  <= S_AADR;
              end else begin
                wr_stb  <= 1'b1;
                wr_addr <= ptr;
                wr_data <= sh;
                ptr     <= page_next;
                sda_oe  <= 1'b1;
                state   <= S_ADAT;
              end
            end
          end
          S_ADEV: begin
            if (scl_fall) begin
              if (rw) begin
                sh     <= rd_data;
                sda_oe <= ~rd_data[BYTE_W-1];
                ptr    <= ptr + 1'b1;
                cnt    <= '0;
                state  <= S_TX;
              end else begin
                sda_oe <= 1'b0;
                state  <= S_ADR;
              end
            end
          end
          S_AADR, S_ADAT: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              state  <= S_DAT;
            end
          end
          S_TX: begin
            if (scl_fall) begin
              if (cnt == LAST) begin
                sda_oe <= 1'b0;
                state  <= S_MACK;
              end else begin
                sh     <= {sh[BYTE_W-2:0], 1'b0};
                sda_oe <= ~sh[BYTE_W-2];
                cnt    <= cnt + 1'b1;
              end
            end
          end
          S_MACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                sh     <= rd_data;
                sda_oe <= ~rd_data[BYTE_W-1];
                ptr    <= ptr + 1'b1;
                cnt    <= '0;
                state  <= S_TX;
              end else begin
                state  <= S_IDLE;
              end
            end
          end
          default: begin
            sda_oe <= 1'b0;
          end
        endcase
      end
    end
  end

  // R1: a Start always lands in a fresh device byte with the line released
  assert_start_restarts_R1: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (state == S_DEV && cnt == '0 && !sda_oe));

  // R3: idle never pulls the data line
  assert_idle_released_R3: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE) |-> !sda_oe);

  // R9: a full device byte seen while busy is never acknowledged
  assert_busy_refused_R9: assert property (@(posedge clk) disable iff (rst)
    (state == S_DEV && scl_fall && cnt == FULL && busy && !start_det && !stop_det)
      |=> !sda_oe);

  // R11: drive moves only after a bus-clock fall or a Start/Stop
  assert_hold_between_falls_R11: assert property (@(posedge clk) disable iff (rst)
    (!scl_fall && !start_det && !stop_det) |=> $stable(sda_oe));
endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
  import twi_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int PAGE_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [2:0]         strap_i,
  input  logic               busy_i,
  output logic               sda_oe_o,
  output logic               wr_stb_o,
  output logic [ADDR_W-1:0]  wr_addr_o,
  output logic [BYTE_W-1:0]  wr_data_o
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [ADDR_W-1:0] ptr;
  logic [BYTE_W-1:0] rd_data;

  twi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  twi_engine #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .strap     (strap_i),
    .busy      (busy_i),
    .rd_data   (rd_data),
    .ptr       (ptr),
    .sda_oe    (sda_oe_o),
    .wr_stb    (wr_stb_o),
    .wr_addr   (wr_addr_o),
    .wr_data   (wr_data_o)
  );

  twi_regfile #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_mem (
    .clk   (clk),
    .we    (wr_stb_o),
    .waddr (wr_addr_o),
    .wdata (wr_data_o),
    .raddr (ptr),
    .rdata (rd_data)
  );

  // R4: every write strobe lasts exactly one cycle
  assert_single_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    wr_stb_o |=> !wr_stb_o);
endmodule

// File: tb/sim_twi_mem_slave.sv
module sim_twi_mem_slave;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic [2:0] strap = 3'b101;
  logic busy = 1'b0;
  logic sda_oe, wr_stb;
  logic [7:0] wr_addr, wr_data;
  logic sda_bus;

  int checks = 0;
  int fails  = 0;
  int stb_cnt = 0;
  int hold_bad = 0;
  logic [7:0] last_wa, last_wd;
  logic [7:0] model [256];
  bit finished = 1'b0;

  localparam logic [7:0] DEV_W = 8'hAA;
  localparam logic [7:0] DEV_R = 8'hAB;

  assign sda_bus = m_sda & ~sda_oe;

  always #10 clk = ~clk;

  twi_mem_slave u0 (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_bus), .strap_i(strap),
    .busy_i(busy), .sda_oe_o(sda_oe), .wr_stb_o(wr_stb),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  always @(negedge clk) begin
    if (!rst && wr_stb) begin
      stb_cnt <= stb_cnt + 1;
      last_wa <= wr_addr;
      last_wd <= wr_data;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(4);
    m_scl = 1'b1; tick(6);
    m_sda = 1'b0; tick(6);
    m_scl = 1'b0; tick(4);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(4);
    m_scl = 1'b1; tick(6);
    m_sda = 1'b1; tick(8);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; tick(4);
      m_scl = 1'b1; tick(8);
      m_scl = 1'b0; tick(4);
    end
  endtask

  task automatic write_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    m_sda = 1'b1; tick(4);
    m_scl = 1'b1; tick(4);
    ack = ~sda_bus;
    tick(4);
    m_scl = 1'b0; tick(4);
  endtask

  task automatic read_byte(output logic [7:0] b, input bit more);
    logic s1;
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(4);
      m_scl = 1'b1; tick(1);
      s1 = sda_bus; tick(6);
      b[i] = sda_bus;
      if (s1 != sda_bus) hold_bad++;
      tick(1);
      m_scl = 1'b0; tick(4);
    end
    m_sda = ~more; tick(4);
    m_scl = 1'b1; tick(8);
    m_scl = 1'b0; tick(4);
    m_sda = 1'b1;
  endtask

  task automatic addr_read(input logic [7:0] a, input int n, input string req);
    bit ack;
    logic [7:0] v;
    bus_start();
    write_byte(DEV_W, ack); check(req, ack, 1);
    write_byte(a, ack);     check(req, ack, 1);
    bus_start();
    write_byte(DEV_R, ack); check(req, ack, 1);
    for (int k = 0; k < n; k++) begin
      read_byte(v, k != n - 1);
      check(req, v, model[8'(a + k)]);
    end
    bus_stop();
  endtask

  task automatic cur_read(input logic [7:0] exp_addr, input string req);
    bit ack;
    logic [7:0] v;
    bus_start();
    write_byte(DEV_R, ack); check(req, ack, 1);
    read_byte(v, 1'b0);
    check(req, v, model[exp_addr]);
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    bit ack;
    int s0;
    tick(5);
    rst = 1'b0;
    tick(4);
    check("R1 reset release", sda_oe, 0);
    check("R1 reset strobe", wr_stb, 0);

    // R2: sweep select bits against strap 101
    for (int a = 0; a < 8; a++) begin
      bus_start();
      write_byte({4'hA, 3'(a), 1'b0}, ack);
      check("R2 address sweep", ack, (a == 5) ? 1 : 0);
      bus_stop();
    end
    bus_start();
    write_byte({4'h6, 3'b101, 1'b0}, ack);
    check("R2 wrong prefix", ack, 0);
    bus_stop();

    // R3: mismatch then silence
    s0 = stb_cnt;
    bus_start();
    write_byte(8'hA0, ack); check("R3 mismatch nack", ack, 0);
    write_byte(8'h10, ack); check("R3 ignored addr", ack, 0);
    write_byte(8'h77, ack); check("R3 ignored data", ack, 0);
    check("R3 no strobe", stb_cnt, s0);
    check("R3 released", sda_oe, 0);
    bus_stop();

    // R4: fill the array page by page
    for (int p = 0; p < 16; p++) begin
      bus_start();
      write_byte(DEV_W, ack); check("R4 dev ack", ack, 1);
      write_byte(8'(p * 16), ack); check("R4 addr ack", ack, 1);
      for (int k = 0; k < 16; k++) begin
        logic [7:0] ad;
        logic [7:0] dv;
        ad = 8'(p * 16 + k);
        dv = 8'(ad * 37 + 11);
        s0 = stb_cnt;
        write_byte(dv, ack);
        model[ad] = dv;
        check("R4 data ack", ack, 1);
        check("R4 strobe count", stb_cnt, s0 + 1);
        check("R4 strobe addr", last_wa, ad);
        check("R4 strobe data", last_wd, dv);
      end
      bus_stop();
    end

    // R5: page wrap on write
    bus_start();
    write_byte(DEV_W, ack);
    write_byte(8'h2E, ack);
    write_byte(8'h5A, ack); model[8'h2E] = 8'h5A;
    write_byte(8'h5B, ack); model[8'h2F] = 8'h5B;
    write_byte(8'h5C, ack); model[8'h20] = 8'h5C;
    check("R5 wrap addr", last_wa, 8'h20);
    bus_stop();

    // R6: random reads
    addr_read(8'h2F, 1, "R6 random");
    addr_read(8'h20, 1, "R6 random wrapped byte");
    addr_read(8'h83, 1, "R6 random");

    // R7: current address reads
    cur_read(8'h84, "R7 after read");
    addr_read(8'hFF, 1, "R6 random top");
    cur_read(8'h00, "R7 wrap to zero");
    bus_start();
    write_byte(DEV_W, ack);
    write_byte(8'h40, ack);
    write_byte(8'hC3, ack); model[8'h40] = 8'hC3;
    bus_stop();
    cur_read(8'h41, "R7 after write");

    // R8 and R11: sequential reads
    hold_bad = 0;
    addr_read(8'hFE, 4, "R8 wrap sequential");
    addr_read(8'h00, 256, "R8 full sweep");
    check("R11 stable while clock high", hold_bad, 0);

    // R9: busy refusal and poll
    busy = 1'b1;
    bus_start();
    write_byte(DEV_W, ack); check("R9 busy nack", ack, 0);
    bus_stop();
    busy = 1'b0;
    bus_start();
    write_byte(DEV_W, ack); check("R9 ready ack", ack, 1);
    bus_stop();

    // R10: abort in mid byte
    bus_start();
    send_bits(DEV_W, 4);
    addr_read(8'h10, 2, "R10 after abort");

    check("R1 idle release", sda_oe, 0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule